// File: doc/BRIEF.md
# Narrow-Port Read Packer and Buffer

This unit sits on the read path between a bus controller and either a cache refill port or a CPU load port. The bus controller hands it a stream of beats from a memory port that is 8, 16 or 32 bits wide. The unit combines those beats into full 32-bit words, so software and the cache see whole words whatever the width of the port. Instruction fetches and data loads go through the same packing logic. A one-bit tag carried with each request tells the consumer which of the two it was.

Each read starts with a request pulse. The pulse latches the port width, the read size and the tag, and it clears all beat and word state. A single-word read hands its word on the cycle after the word is complete. A quad-word read holds the assembled words in a four-entry buffer. It releases nothing until all four are present, and then sends them back to back with a word index, under a ready/valid handshake. An abort input drops any partial word and any queued words.

Top module: `narrow_read_packer`

## Requirements
- R1: After reset, out_valid_o is low.
- R2: With width code 0 (8-bit port), four accepted beats make one word. Bits [7:0] of beat k land in word bits [8k+7:8k]. The upper beat bits are ignored. Idle cycles between beats have no effect.
- R3: With width code 1 (16-bit port), two beats make one word. Bits [15:0] of beat k land in word bits [16k+15:16k].
- R4: With width code 2 (32-bit port), a single beat is a whole word. Width code 3 behaves exactly like code 2.
- R5: For a single-word read (req_quad_i low), out_valid_o rises on the cycle after the beat that completes the word, with out_idx_o 0 and out_last_o high. A partial word is never presented.
- R6: For a quad read (req_quad_i high), out_valid_o stays low until the fourth word is complete. It rises on the cycle after the beat that completes the fourth word.
- R7: Once a quad release has started and out_ready_i is high, the four words appear on consecutive cycles in assembly order, with out_idx_o running 0,1,2,3. out_last_o is high only on index 3, and out_valid_o drops afterwards.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o and out_idx_o hold their values.
- R9: out_fetch_o equals the req_fetch_i value latched with the current request.
- R10: A request pulse discards all beat, word and queue state. A beat presented in the same cycle as the request pulse is ignored.
- R11: An abort pulse discards the partial word and all queued words. out_valid_o is low on the next cycle, and beats are ignored until the next request.
- R12: Beats that arrive after a request's words are all assembled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start of a new read request (one-cycle pulse) |
| req_quad_i | input | 1 | 1 selects a quad-word read, 0 a single-word read |
| req_fetch_i | input | 1 | Tag for the request: 1 for an instruction fetch, 0 for a data load |
| req_width_i | input | 2 | Port width code: 0 for 8-bit, 1 for 16-bit, 2 or 3 for 32-bit |
| abort_i | input | 1 | Drops the read in progress |
| beat_valid_i | input | 1 | A bus beat is present this cycle |
| beat_data_i | input | 32 | Beat data; a narrow port drives the low lanes |
| out_valid_o | output | 1 | An assembled word is on offer |
| out_ready_i | input | 1 | The consumer takes the offered word |
| out_data_o | output | 32 | Assembled word |
| out_idx_o | output | 2 | Index of the word within the line |
| out_last_o | output | 1 | Last word of the read |
| out_fetch_o | output | 1 | Tag of the request |

## Verification
The bench sweeps every width code, both read sizes and both tag values. It drives the upper beat bits with data that must be discarded, and it inserts idle gaps between beats. A wrong lane rule would place bytes in the wrong position or let upper bits through. A quad buffer that released early would raise valid before the fourth word. A broken burst would leave holes, or skip or repeat an index. The bench also stalls the consumer in the middle of a line, aborts part-way through single and quad reads and then feeds more beats, restarts a read in the middle of a line, and sends surplus beats after a single read. A design that kept stale lanes or a stale count after any of these would produce wrong words or an extra valid.

// File: rtl/rdpk_pkg.sv
package rdpk_pkg;
  // clamp a width code to the widest legal port
  function automatic int unsigned eff_code(int unsigned code, int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction
endpackage

// File: rtl/rdpk_lane_asm.sv
module rdpk_lane_asm #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WC_W   = $clog2(LIDX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              beat_en_i,
  input  logic [WC_W-1:0]   wcode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_done_o
);
  import rdpk_pkg::*;

  logic [WC_W-1:0]                 eff_wc;
  logic [LIDX_W-1:0]               beats_m1, mask, beat_cnt_q;
  logic [LANES-1:0][BYTE_W-1:0]    data_b, merged, acc_q;

  assign eff_wc   = WC_W'(eff_code(int'(wcode_i), LIDX_W));
  assign beats_m1 = LIDX_W'((LANES >> eff_wc) - 1);
  assign mask     = LIDX_W'((1 << eff_wc) - 1);
  assign data_b   = data_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LIDX_W-1:0] sel_beat, src;
    logic              hit;
    assign sel_beat  = LIDX_W'(l) >> eff_wc;
    assign src       = LIDX_W'(l) & mask;
    assign hit       = beat_en_i && (beat_cnt_q == sel_beat);
    assign merged[l] = hit ? data_b[src] : acc_q[l];
  end

  assign word_o      = merged;
  assign word_done_o = beat_en_i && (beat_cnt_q == beats_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_cnt_q <= '0;
      acc_q      <= '0;
    end else if (clr_i) begin
      beat_cnt_q <= '0;
      acc_q      <= '0;
    end else if (beat_en_i) begin
      beat_cnt_q <= word_done_o ? '0 : beat_cnt_q + 1'b1;
      acc_q      <= word_done_o ? '0 : merged;
    end
  end
endmodule

// File: rtl/rdpk_fifo.sv
module rdpk_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     rd_data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign do_push   = push_i && !full_o;
  assign do_pop    = pop_i && !empty_o;
  assign rd_data_o = mem_q[rd_q];
  assign cnt_o     = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end
endmodule

// File: rtl/rdpk_ctrl.sv
module rdpk_ctrl #(
  parameter int DEPTH = 4,
  parameter int WC_W  = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_quad_i,
  input  logic             req_fetch_i,
  input  logic [WC_W-1:0]  req_width_i,
  input  logic             abort_i,
  input  logic             beat_valid_i,
  input  logic             word_done_i,
  input  logic             fifo_empty_i,
  input  logic             fifo_full_i,
  input  logic             out_ready_i,
  output logic             clr_o,
  output logic             beat_en_o,
  output logic             pop_o,
  output logic [WC_W-1:0]  wcode_o,
  output logic             quad_o,
  output logic             out_valid_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic             out_last_o,
  output logic             out_fetch_o
);
  logic             active_q, quad_q, fetch_q, drain_q;
  logic [WC_W-1:0]  wcode_q;
  logic [IDX_W-1:0] word_cnt_q, idx_q, words_m1;
  logic             final_word;

  assign clr_o       = req_i || abort_i;
  assign beat_en_o   = active_q && beat_valid_i && !clr_o;
  assign words_m1    = quad_q ? IDX_W'(DEPTH - 1) : '0;
  assign final_word  = word_done_i && (word_cnt_q == words_m1);
  // quad lines wait for a full buffer; singles go straight out
  assign out_valid_o = !fifo_empty_i && (!quad_q || drain_q || fifo_full_i);
  assign pop_o       = out_valid_o && out_ready_i;
  assign out_idx_o   = idx_q;
  assign out_last_o  = (idx_q == words_m1);
  assign out_fetch_o = fetch_q;
  assign wcode_o     = wcode_q;
  assign quad_o      = quad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      quad_q     <= 1'b0;
      fetch_q    <= 1'b0;
      drain_q    <= 1'b0;
      wcode_q    <= '0;
      word_cnt_q <= '0;
      idx_q      <= '0;
    end else if (clr_o) begin
      active_q   <= req_i && !abort_i;
      drain_q    <= 1'b0;
      word_cnt_q <= '0;
      idx_q      <= '0;
      if (req_i) begin
        quad_q  <= req_quad_i;
        fetch_q <= req_fetch_i;
        wcode_q <= req_width_i;
      end
    end else begin
      if (word_done_i) word_cnt_q <= word_cnt_q + 1'b1;
      if (final_word)  active_q   <= 1'b0;
      if (fifo_full_i) drain_q    <= 1'b1;
      if (pop_o)       idx_q      <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/narrow_read_packer.sv
module narrow_read_packer #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WC_W   = $clog2(LIDX_W + 1),
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_quad_i,
  input  logic              req_fetch_i,
  input  logic [WC_W-1:0]   req_width_i,
  input  logic              abort_i,
  input  logic              beat_valid_i,
  input  logic [DATA_W-1:0] beat_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic              out_last_o,
  output logic              out_fetch_o
);
  logic              clr, beat_en, pop, word_done, fifo_empty, fifo_full, mode_quad;
  logic [WC_W-1:0]   wcode;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  fifo_cnt;

  rdpk_ctrl #(.DEPTH(DEPTH), .WC_W(WC_W)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .req_quad_i, .req_fetch_i, .req_width_i, .abort_i,
    .beat_valid_i, .word_done_i(word_done), .fifo_empty_i(fifo_empty),
    .fifo_full_i(fifo_full), .out_ready_i, .clr_o(clr), .beat_en_o(beat_en),
    .pop_o(pop), .wcode_o(wcode), .quad_o(mode_quad), .out_valid_o, .out_idx_o,
    .out_last_o, .out_fetch_o
  );

  rdpk_lane_asm #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_asm (
    .clk_i, .rst_ni, .clr_i(clr), .beat_en_i(beat_en), .wcode_i(wcode),
    .data_i(beat_data_i), .word_o(word), .word_done_o(word_done)
  );

  rdpk_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(word_done), .push_data_i(word),
    .pop_i(pop), .rd_data_o(out_data_o), .cnt_o(fifo_cnt), .empty_o(fifo_empty),
    .full_o(fifo_full)
  );
endmodule

// File: rtl/narrow_read_packer_chk.sv
module narrow_read_packer_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              abort_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic [IDX_W-1:0]  out_idx_o,
  input logic              out_last_o,
  input logic              mode_quad,
  input logic [CNT_W-1:0]  fifo_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH)); // R6
  AST_QUAD_FULL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_valid_o) && mode_quad) |-> fifo_cnt == CNT_W'(DEPTH)); // R6
  AST_SINGLE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !mode_quad) |-> (out_last_o && out_idx_o == '0)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !req_i && !abort_i)
      |=> (out_valid_o && $stable(out_data_o) && $stable(out_idx_o))); // R8
  AST_BURST_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o && mode_quad && !req_i && !abort_i)
      |=> out_valid_o); // R7
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o && !req_i && !abort_i)
      |=> out_idx_o == $past(out_idx_o) + 1'b1); // R7
  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !out_valid_o); // R11
endmodule

bind narrow_read_packer narrow_read_packer_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .abort_i(abort_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_idx_o(out_idx_o), .out_last_o(out_last_o), .mode_quad(mode_quad),
  .fifo_cnt(fifo_cnt)
);

// File: tb/narrow_read_packer_test.sv
module narrow_read_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_quad = 1'b0, req_fetch = 1'b0, abort = 1'b0;
  logic [1:0]  req_width = 2'd0;
  logic        beat_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] beat_data = '0;
  logic        out_valid, out_last, out_fetch;
  logic [31:0] out_data;
  logic [1:0]  out_idx;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  narrow_read_packer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_quad_i(req_quad),
    .req_fetch_i(req_fetch), .req_width_i(req_width), .abort_i(abort),
    .beat_valid_i(beat_valid), .beat_data_i(beat_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_idx_o(out_idx),
    .out_last_o(out_last), .out_fetch_o(out_fetch)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bv(int s, int k);
    return (32'(s) * 32'h9E3779B1) ^ (32'(k) * 32'h01230457) ^ 32'hA5C30F1E;
  endfunction

  function automatic int nbeats(int w);
    int ew = (w > 2) ? 2 : w;
    return 4 >> ew;
  endfunction

  function automatic logic [31:0] exp_word(int w, int s, int wd);
    int nb = nbeats(w);
    int bits = 32 / nb;
    logic [31:0] m = (bits == 32) ? 32'hFFFFFFFF : ((32'h1 << bits) - 1);
    logic [31:0] r = '0;
    for (int b = 0; b < nb; b++) r |= (bv(s, wd * nb + b) & m) << (bits * b);
    return r;
  endfunction

  function automatic string wtag(int w);
    return (w == 0) ? "R2" : (w == 1) ? "R3" : "R4";
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic beat(logic [31:0] d);
    beat_valid = 1'b1; beat_data = d;
    step();
    beat_valid = 1'b0;
  endtask

  // R10: a beat driven with the request must be ignored
  task automatic do_req(int w, bit q, bit f);
    req = 1'b1; req_quad = q; req_fetch = f; req_width = 2'(w);
    beat_valid = 1'b1; beat_data = 32'hDEADBEEF;
    step();
    req = 1'b0; beat_valid = 1'b0;
  endtask

  task automatic do_abort();
    abort = 1'b1;
    step();
    abort = 1'b0;
    chk(out_valid == 1'b0, "R11 valid after abort", 32'(out_valid), 0);
  endtask

  task automatic collect(int w, bit q, bit f, int s, int nw);
    for (int i = 0; i < nw; i++) begin
      chk(out_valid == 1'b1, q ? "R7 burst valid" : "R5 single valid", 32'(out_valid), 1);
      chk(out_data == exp_word(w, s, i), wtag(w), out_data, exp_word(w, s, i));
      chk(out_idx == 2'(i), "R7 index", 32'(out_idx), i);
      chk(out_last == (i == nw - 1), q ? "R7 last" : "R5 last", 32'(out_last), 32'(i == nw - 1));
      chk(out_fetch == f, "R9 fetch tag", 32'(out_fetch), 32'(f));
      step();
    end
    chk(out_valid == 1'b0, "R7 valid after read", 32'(out_valid), 0);
  endtask

  task automatic feed(int w, bit q, int s, bit gap, int nw);
    int nb = nbeats(w);
    for (int wd = 0; wd < nw; wd++)
      for (int b = 0; b < nb; b++) begin
        beat(bv(s, wd * nb + b));
        if (!(wd == nw - 1 && b == nb - 1)) begin
          chk(out_valid == 1'b0, q ? "R6 early release" : "R5 partial word", 32'(out_valid), 0);
          if (gap) step();
        end
      end
  endtask

  task automatic run(int w, bit q, bit f, int s, bit gap);
    int nw = q ? 4 : 1;
    do_req(w, q, f);
    feed(w, q, s, gap, nw);
    collect(w, q, f, s, nw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 0);
    step();
    rst_n = 1'b1;
    step();
    chk(out_valid == 1'b0, "R1 after reset", 32'(out_valid), 0);

    // sweep of widths, read sizes, tags, with and without gaps
    for (int w = 0; w < 4; w++)
      for (int q = 0; q < 2; q++)
        for (int f = 0; f < 2; f++)
          for (int s = 1; s < 3; s++)
            run(w, q[0], f[0], w * 16 + q * 8 + f * 4 + s, s[0]);

    // R8: stall a quad line mid-burst
    do_req(1, 1'b1, 1'b0);
    out_ready = 1'b0;
    feed(1, 1'b1, 77, 1'b0, 4);
    for (int i = 0; i < 3; i++) begin
      chk(out_valid == 1'b1, "R8 stall valid", 32'(out_valid), 1);
      chk(out_data == exp_word(1, 77, 0), "R8 stall data", out_data, exp_word(1, 77, 0));
      step();
    end
    out_ready = 1'b1; step();
    out_ready = 1'b0;
    for (int i = 0; i < 2; i++) begin
      chk(out_valid == 1'b1, "R8 stall mid valid", 32'(out_valid), 1);
      chk(out_idx == 2'd1, "R8 stall idx", 32'(out_idx), 1);
      chk(out_data == exp_word(1, 77, 1), "R8 stall mid data", out_data, exp_word(1, 77, 1));
      step();
    end
    out_ready = 1'b1;
    for (int i = 1; i < 4; i++) begin
      chk(out_data == exp_word(1, 77, i) && out_idx == 2'(i), "R7 after stall",
          out_data, exp_word(1, 77, i));
      step();
    end
    chk(out_valid == 1'b0, "R7 end after stall", 32'(out_valid), 0);

    // R11: abort a partial single word, then beats are ignored
    do_req(0, 1'b0, 1'b1);
    beat(32'h11); beat(32'h22);
    do_abort();
    for (int i = 0; i < 5; i++) begin
      beat(32'h33 + 32'(i));
      chk(out_valid == 1'b0, "R11 beats ignored", 32'(out_valid), 0);
    end
    run(0, 1'b0, 1'b1, 91, 1'b0);

    // R11: abort a quad read with two words queued
    do_req(2, 1'b1, 1'b0);
    beat(32'hAAAA0001); beat(32'hAAAA0002);
    do_abort();
    for (int i = 0; i < 4; i++) begin
      beat(32'hBBBB0000 + 32'(i));
      chk(out_valid == 1'b0, "R11 quad beats ignored", 32'(out_valid), 0);
    end
    run(2, 1'b1, 1'b0, 92, 1'b0);

    // R10: restart in the middle of a quad line
    do_req(0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) beat(32'hC0 + 32'(i));
    do_req(1, 1'b0, 1'b1);
    chk(out_valid == 1'b0, "R10 restart clears", 32'(out_valid), 0);
    feed(1, 1'b0, 93, 1'b0, 1);
    collect(1, 1'b0, 1'b1, 93, 1);

    // R12: surplus beats after a single read
    run(2, 1'b0, 1'b0, 94, 1'b0);
    for (int i = 0; i < 3; i++) begin
      beat(32'hE0 + 32'(i));
      chk(out_valid == 1'b0, "R12 surplus beat", 32'(out_valid), 0);
    end
    run(1, 1'b1, 1'b1, 95, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule